// File: doc/BRIEF.md
# Two-Channel Blink Controller Register Slave on a Two-Wire Serial Bus

This block is a two-wire serial bus target that sits behind a glitch filter and gives a host access to a small register file. It stores the settings of a two-channel LED blinker: two period prescalers, two duty values and one selector byte that chooses each LED's source. It also reports the live state of the two LED pins through a read-only register. The bus lines are sampled with the fast system clock. Each line passes through a two-flop synchronizer and then a stable-count filter, so short spikes never reach the protocol logic.

A host first sends the 7-bit address with the direction bit. In a write, the first byte after the address is a command byte. It holds a 3-bit register pointer and an auto-increment flag. Every later byte is written to the register the pointer selects. A read returns bytes starting at the current pointer. The host ends a read by not acknowledging the last byte. The pointer and the flag persist across transactions. The block only sees and pulls down SDA. The open-drain pads, the power-on circuit and clock stretching are outside it.

Top module: `blink_i2c_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal `1100000` with the last bit replaced by `addr_sel`. To acknowledge, `sda_pull` is high throughout the ninth SCL clock. Bit 0 of the address byte is the direction: 1 means read, 0 means write.
- R2: After an address byte that does not match, the block does not acknowledge. `sda_pull` then stays low until the next START.
- R3: In a write, the first byte after the address loads the command. Bit 4 of that byte is the auto-increment flag and bits 2..0 are the pointer. The command resets to 00h.
- R4: Register 1 drives `prescale0`, register 2 drives `duty0`, register 3 drives `prescale1`, register 4 drives `duty1` and register 5 drives `led_mode`. Their reset values are FFh, 80h, FFh, 80h and 55h.
- R5: While the flag is clear, the pointer does not move. Successive data bytes all go to the same register, and repeated reads return the same register.
- R6: While the flag is set, the pointer advances after each data byte written and after each byte loaded for reading. From pointer 5, 6 or 7 it goes to 0; otherwise it goes to pointer+1.
- R7: Register 0 acknowledges writes and ignores them. A read of register 0 returns `pin_state` in bits 1..0, with zeros above.
- R8: A read sends data most significant bit first, starting at the pointer. After a not-acknowledge from the host, `sda_pull` is low and stays low until the next START. A STOP also releases `sda_pull`.
- R9: While `rst_n` is low, the registers and the command hold their reset values and `sda_pull` is low.
- R10: A START received in the middle of a transaction (a repeated START) restarts address decoding. The pointer keeps its value.
- R11: Pointers 6 and 7 read as 00h and ignore writes, while still acknowledging them.
- R12: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks has no effect on the bus protocol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 1 | Selects the low bit of the bus address |
| pin_state | input | NUM_PINS | Live state of the LED pins, read back through register 0 |
| sda_pull | output | 1 | High pulls SDA low (acknowledge or a zero data bit) |
| prescale0 | output | 8 | Period prescaler of blink source 0 |
| duty0 | output | 8 | Duty value of blink source 0 |
| prescale1 | output | 8 | Period prescaler of blink source 1 |
| duty1 | output | 8 | Duty value of blink source 1 |
| led_mode | output | 8 | LED source selector byte |

## Verification
The in-line assertions watch several behaviours on every cycle:
- the filtered lines only ever move toward the synchronized input;
- the pointer changes only on a filtered SCL falling edge and wraps to 0 from the top of the map;
- a write to register 0 leaves the stored bytes unchanged;
- SDA is released after a STOP, after an address mismatch and after a host not-acknowledge.

The bench's scenarios are the only evidence for the end-to-end byte values. These cover burst and single-register writes, wrap-around, reads across the whole map including the unused pointers, the repeated START hand-over, rejection of injected spikes, and reset in the middle of a transfer.

// File: rtl/blink_i2c_pkg.sv
package blink_i2c_pkg;

    localparam int BYTE_W   = 8;
    localparam int PTR_W    = 3;
    localparam int AI_BIT   = 4;

    localparam logic [PTR_W-1:0] REG_INPUT = 3'd0;
    localparam logic [PTR_W-1:0] REG_PSC0  = 3'd1;
    localparam logic [PTR_W-1:0] REG_DUTY0 = 3'd2;
    localparam logic [PTR_W-1:0] REG_PSC1  = 3'd3;
    localparam logic [PTR_W-1:0] REG_DUTY1 = 3'd4;
    localparam logic [PTR_W-1:0] REG_LSEL  = 3'd5;
    localparam logic [PTR_W-1:0] LAST_REG  = REG_LSEL;

    localparam logic [BYTE_W-1:0] PSC_RST  = 8'hFF;
    localparam logic [BYTE_W-1:0] DUTY_RST = 8'h80;
    localparam logic [BYTE_W-1:0] LSEL_RST = 8'h55;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WR,
        ST_RD
    } bus_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] psc0;
        logic [BYTE_W-1:0] duty0;
        logic [BYTE_W-1:0] psc1;
        logic [BYTE_W-1:0] duty1;
        logic [BYTE_W-1:0] lsel;
    } regs_t;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p, input logic ai);
        if (!ai)
            return p;
        if (p >= LAST_REG)
            return '0;
        return p + 1'b1;
    endfunction

endpackage

// File: rtl/blink_i2c_deglitch.sv
module blink_i2c_deglitch #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FILT_LEN - 1);

    typedef struct packed {
        logic [1:0]       sync;
        logic [CNT_W-1:0] cnt;
        logic             filt;
    } flt_t;

    flt_t q, n;

    always_comb begin
        n      = q;
        n.sync = {q.sync[0], line_i};
        if (q.sync[1] != q.filt) begin
            if (q.cnt == CNT_TOP) begin
                n.filt = q.sync[1];
                n.cnt  = '0;
            end else begin
                n.cnt = q.cnt + 1'b1;
            end
        end else begin
            n.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '{sync: 2'b11, cnt: '0, filt: 1'b1};
        else
            q <= n;
    end

    assign line_o = q.filt;

    // R12
    filt_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.filt) |-> (q.filt == $past(q.sync[1])));

endmodule

// File: rtl/blink_i2c_regs.sv
module blink_i2c_regs
    import blink_i2c_pkg::*;
#(
    parameter int NUM_PINS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [PTR_W-1:0]    wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic [PTR_W-1:0]    rd_addr,
    input  logic [NUM_PINS-1:0] pins,
    output logic [BYTE_W-1:0]   rd_data,
    output regs_t               regs
);
    localparam int PAD_W = BYTE_W - NUM_PINS;

    regs_t q, n;

    always_comb begin
        n = q;
        if (wr_en) begin
            case (wr_addr)
                REG_PSC0:  n.psc0  = wr_data;
                REG_DUTY0: n.duty0 = wr_data;
                REG_PSC1:  n.psc1  = wr_data;
                REG_DUTY1: n.duty1 = wr_data;
                REG_LSEL:  n.lsel  = wr_data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '{psc0: PSC_RST, duty0: DUTY_RST, psc1: PSC_RST,
                   duty1: DUTY_RST, lsel: LSEL_RST};
        else
            q <= n;
    end

    always_comb begin
        case (rd_addr)
            REG_INPUT: rd_data = {{PAD_W{1'b0}}, pins};
            REG_PSC0:  rd_data = q.psc0;
            REG_DUTY0: rd_data = q.duty0;
            REG_PSC1:  rd_data = q.psc1;
            REG_DUTY1: rd_data = q.duty1;
            REG_LSEL:  rd_data = q.lsel;
            default:   rd_data = '0;
        endcase
    end

    assign regs = q;

    // R7
    input_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_INPUT) |=> $stable(q));

    // R11
    spare_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > LAST_REG) |=> $stable(q));

endmodule

// File: rtl/blink_i2c_slave.sv
module blink_i2c_slave
    import blink_i2c_pkg::*;
#(
    parameter int          FILT_LEN    = 4,
    parameter int          NUM_PINS    = 2,
    parameter logic [5:0]  DEV_ADDR_HI = 6'b110000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic                addr_sel,
    input  logic [NUM_PINS-1:0] pin_state,
    output logic                sda_pull,
    output logic [7:0]          prescale0,
    output logic [7:0]          duty0,
    output logic [7:0]          prescale1,
    output logic [7:0]          duty1,
    output logic [7:0]          led_mode
);
    localparam int NUM_LINES = 2;
    localparam int LINE_SCL  = 1;
    localparam int LINE_SDA  = 0;

    typedef struct packed {
        bus_state_e        st;
        logic [3:0]        bitcnt;
        logic [BYTE_W-1:0] shreg;
        logic              in_ack;
        logic              rw;
        logic [PTR_W-1:0]  ptr;
        logic              ai;
        logic              drive;
        logic              scl_prev;
        logic              sda_prev;
    } bus_t;

    localparam bus_t BUS_RST = '{st: ST_IDLE, bitcnt: '0, shreg: '0, in_ack: 1'b0,
                                 rw: 1'b0, ptr: '0, ai: 1'b0, drive: 1'b0,
                                 scl_prev: 1'b1, sda_prev: 1'b1};

    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] flt_lines;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        blink_i2c_deglitch #(.FILT_LEN(FILT_LEN)) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (flt_lines[g])
        );
    end

    bus_t q, n;
    logic scl_f, sda_f;
    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic [6:0] dev_addr;
    logic              wr_en;
    logic [BYTE_W-1:0] rd_data;
    regs_t             regs;

    assign scl_f    = flt_lines[LINE_SCL];
    assign sda_f    = flt_lines[LINE_SDA];
    assign scl_rise = scl_f & ~q.scl_prev;
    assign scl_fall = ~scl_f & q.scl_prev;
    assign start_ev = scl_f & q.scl_prev & q.sda_prev & ~sda_f;
    assign stop_ev  = scl_f & q.scl_prev & ~q.sda_prev & sda_f;
    assign dev_addr = {DEV_ADDR_HI, addr_sel};

    always_comb begin
        n          = q;
        wr_en      = 1'b0;
        n.scl_prev = scl_f;
        n.sda_prev = sda_f;
        if (start_ev) begin
            n.st     = ST_ADDR;
            n.bitcnt = '0;
            n.in_ack = 1'b0;
            n.drive  = 1'b0;
        end else if (stop_ev) begin
            n.st     = ST_IDLE;
            n.bitcnt = '0;
            n.in_ack = 1'b0;
            n.drive  = 1'b0;
        end else if (scl_rise) begin
            if ((q.st == ST_ADDR || q.st == ST_CMD || q.st == ST_WR) && !q.in_ack) begin
                n.shreg  = {q.shreg[BYTE_W-2:0], sda_f};
                n.bitcnt = q.bitcnt + 1'b1;
            end else if (q.st == ST_RD && q.in_ack && sda_f) begin
                n.st     = ST_IDLE;
                n.in_ack = 1'b0;
                n.drive  = 1'b0;
            end
        end else if (scl_fall) begin
            case (q.st)
                ST_ADDR, ST_CMD, ST_WR: begin
                    if (!q.in_ack) begin
                        if (q.bitcnt == 4'd8) begin
                            if (q.st == ST_ADDR && q.shreg[7:1] != dev_addr) begin
                                n.st = ST_IDLE;
                            end else begin
                                n.in_ack = 1'b1;
                                n.drive  = 1'b1;
                                if (q.st == ST_ADDR)
                                    n.rw = q.shreg[0];
                                if (q.st == ST_CMD) begin
                                    n.ai  = q.shreg[AI_BIT];
                                    n.ptr = q.shreg[PTR_W-1:0];
                                end
                                if (q.st == ST_WR) begin
                                    wr_en = 1'b1;
                                    n.ptr = ptr_step(q.ptr, q.ai);
                                end
                            end
                        end
                    end else begin
                        n.in_ack = 1'b0;
                        n.drive  = 1'b0;
                        n.bitcnt = '0;
                        if (q.st == ST_ADDR) begin
                            if (q.rw) begin
                                n.st    = ST_RD;
                                n.shreg = rd_data;
                                n.drive = ~rd_data[BYTE_W-1];
                                n.ptr   = ptr_step(q.ptr, q.ai);
                            end else begin
                                n.st = ST_CMD;
                            end
                        end else if (q.st == ST_CMD) begin
                            n.st = ST_WR;
                        end
                    end
                end
                ST_RD: begin
                    if (!q.in_ack) begin
                        n.bitcnt = q.bitcnt + 1'b1;
                        if (q.bitcnt == 4'd7) begin
                            n.in_ack = 1'b1;
                            n.drive  = 1'b0;
                        end else begin
                            n.shreg = {q.shreg[BYTE_W-2:0], 1'b0};
                            n.drive = ~q.shreg[BYTE_W-2];
                        end
                    end else begin
                        n.in_ack = 1'b0;
                        n.bitcnt = '0;
                        n.shreg  = rd_data;
                        n.drive  = ~rd_data[BYTE_W-1];
                        n.ptr    = ptr_step(q.ptr, q.ai);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= BUS_RST;
        else
            q <= n;
    end

    blink_i2c_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (q.ptr),
        .wr_data (q.shreg),
        .rd_addr (q.ptr),
        .pins    (pin_state),
        .rd_data (rd_data),
        .regs    (regs)
    );

    assign sda_pull  = q.drive;
    assign prescale0 = regs.psc0;
    assign duty0     = regs.duty0;
    assign prescale1 = regs.psc1;
    assign duty1     = regs.duty1;
    assign led_mode  = regs.lsel;

    // R2
    mismatch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ADDR && scl_fall && !q.in_ack && !start_ev && !stop_ev &&
         q.bitcnt == 4'd8 && q.shreg[7:1] != dev_addr) |=> (!sda_pull && q.st == ST_IDLE));

    // R8
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RD && q.in_ack && scl_rise && sda_f && !start_ev && !stop_ev) |=> !sda_pull);

    // R8
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_pull);

    // R6
    ptr_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.ptr) |-> $past(scl_fall));

    // R6
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && q.ai && q.ptr >= LAST_REG) |=> (q.ptr == '0));

endmodule

// File: tb/blink_i2c_slave_test.sv
`timescale 1ns/1ps
module blink_i2c_slave_test;
    localparam int Q = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic glitch_scl = 1'b0, glitch_sda = 1'b0;
    logic addr_sel = 1'b0;
    logic [1:0] pins = 2'b10;
    logic sda_drv;
    logic [7:0] psc0, dty0, psc1, dty1, lmode;
    logic scl_bus, sda_bus;

    int vectors = 0;
    int fails = 0;
    logic [7:0] m_reg [0:7];
    logic m_ai;
    logic [2:0] m_ptr;
    logic [7:0] wbuf [0:7];
    logic watch_nodrive = 1'b0;
    logic saw_drive = 1'b0;

    assign scl_bus = scl_m | glitch_scl;
    assign sda_bus = sda_m & ~sda_drv & ~glitch_sda;

    always #2 clk = ~clk;

    blink_i2c_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .addr_sel(addr_sel), .pin_state(pins), .sda_pull(sda_drv),
        .prescale0(psc0), .duty0(dty0), .prescale1(psc1), .duty1(dty1), .led_mode(lmode)
    );

    always @(negedge clk) if (watch_nodrive && sda_drv) saw_drive <= 1'b1;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [2:0] nxt(input logic [2:0] p, input logic ai);
        if (!ai) return p;
        return (p >= 3'd5) ? 3'd0 : p + 3'd1;
    endfunction

    function automatic logic [7:0] mread(input logic [2:0] p);
        if (p == 3'd0) return {6'b0, pins};
        if (p > 3'd5) return 8'h00;
        return m_reg[p];
    endfunction

    task automatic model_reset();
        m_reg[1] = 8'hFF; m_reg[2] = 8'h80; m_reg[3] = 8'hFF; m_reg[4] = 8'h80; m_reg[5] = 8'h55;
        m_ai = 1'b0; m_ptr = 3'd0;
    endtask

    task automatic chk_ports(input string tag);
        chk({tag, " prescale0"}, {24'b0, psc0}, {24'b0, m_reg[1]});
        chk({tag, " duty0"},     {24'b0, dty0}, {24'b0, m_reg[2]});
        chk({tag, " prescale1"}, {24'b0, psc1}, {24'b0, m_reg[3]});
        chk({tag, " duty1"},     {24'b0, dty1}, {24'b0, m_reg[4]});
        chk({tag, " led_mode"},  {24'b0, lmode}, {24'b0, m_reg[5]});
    endtask

    task automatic bus_bit(input logic b, output logic s);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(Q);
        s = sda_bus; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            d[i] = s;
        end
        bus_bit(~mack, s);
    endtask

    // write transaction: address, command, n data bytes from wbuf
    task automatic write_txn(input logic [6:0] a7, input logic [7:0] cmd, input int n,
                             input logic exp_ack, input string tag);
        logic ack;
        i2c_start();
        wr_byte({a7, 1'b0}, ack);
        chk({tag, " address ack"}, {31'b0, ack}, {31'b0, exp_ack});
        if (ack) begin
            wr_byte(cmd, ack);
            chk({tag, " command ack"}, {31'b0, ack}, 32'd1);
            m_ai = cmd[4]; m_ptr = cmd[2:0];
            for (int i = 0; i < n; i++) begin
                wr_byte(wbuf[i], ack);
                chk({tag, " data ack"}, {31'b0, ack}, 32'd1);
                if (m_ptr >= 3'd1 && m_ptr <= 3'd5) m_reg[m_ptr] = wbuf[i];
                m_ptr = nxt(m_ptr, m_ai);
            end
        end
        i2c_stop();
    endtask

    // command write, repeated START, then n-byte read
    task automatic read_txn(input logic [7:0] cmd, input int n, input string tag);
        logic ack;
        logic [7:0] d;
        i2c_start();
        wr_byte({6'b110000, addr_sel, 1'b0}, ack);
        wr_byte(cmd, ack);
        m_ai = cmd[4]; m_ptr = cmd[2:0];
        i2c_start();
        wr_byte({6'b110000, addr_sel, 1'b1}, ack);
        chk({tag, " R10 read address ack after repeated START"}, {31'b0, ack}, 32'd1);
        for (int i = 0; i < n; i++) begin
            rd_byte(i != n - 1, d);
            chk({tag, " R8 read byte"}, {24'b0, d}, {24'b0, mread(m_ptr)});
            m_ptr = nxt(m_ptr, m_ai);
        end
        tick(Q);
        chk({tag, " R8 SDA released after not-acknowledge"}, {31'b0, sda_drv}, 32'd0);
        i2c_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, got 200000 cycles expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic ack;
        void'($urandom(32'd1234));
        model_reset();
        tick(5);
        // R9: reset state
        chk("R9 SDA released in reset", {31'b0, sda_drv}, 32'd0);
        rst_n = 1'b1;
        tick(10);
        // R4
        chk_ports("R4 reset values");

        // R1 R3 R6: burst write with auto-increment from register 1
        wbuf[0] = 8'h25; wbuf[1] = 8'h80; wbuf[2] = 8'h09; wbuf[3] = 8'hC0; wbuf[4] = 8'h0E;
        write_txn(7'h60, 8'h11, 5, 1'b1, "R1 R3 R6 burst");
        chk_ports("R4 R6 after burst");

        // R2: wrong address, no drive
        saw_drive = 1'b0; watch_nodrive = 1'b1;
        wbuf[0] = 8'hAA;
        write_txn(7'h61, 8'h01, 1, 1'b0, "R2 mismatch");
        watch_nodrive = 1'b0;
        chk("R2 SDA never pulled on mismatch", {31'b0, saw_drive}, 32'd0);
        chk_ports("R2 registers unchanged");

        // R1: other address pin value
        addr_sel = 1'b1;
        wbuf[0] = 8'h3C;
        write_txn(7'h61, 8'h03, 1, 1'b1, "R1 addr_sel high");
        write_txn(7'h60, 8'h03, 1, 1'b0, "R1 addr_sel high, low address");
        chk_ports("R1 addr_sel high");
        addr_sel = 1'b0;

        // R5: flag clear keeps pointer
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        write_txn(7'h60, 8'h02, 3, 1'b1, "R5 fixed pointer");
        chk_ports("R5 fixed pointer");
        read_txn(8'h02, 3, "R5 repeated reads");

        // R6 R7: wrap through register 0 (ignored)
        wbuf[0] = 8'h44; wbuf[1] = 8'hA6; wbuf[2] = 8'hEE; wbuf[3] = 8'h5A;
        write_txn(7'h60, 8'h14, 4, 1'b1, "R6 R7 wrap");
        chk_ports("R6 R7 wrap");

        // R7 R8 R10: read whole map with wrap to input register
        pins = 2'b01;
        read_txn(8'h11, 6, "R7 R8 full map");

        // R11: spare pointers
        wbuf[0] = 8'h77; wbuf[1] = 8'h66;
        write_txn(7'h60, 8'h06, 1, 1'b1, "R11 write ptr6");
        write_txn(7'h60, 8'h07, 1, 1'b1, "R11 write ptr7");
        chk_ports("R11 spare writes ignored");
        read_txn(8'h16, 2, "R11 read ptr6 then wrap");
        read_txn(8'h07, 1, "R11 read ptr7");

        // R12: spikes on SCL while low and on SDA while high
        begin
            logic s;
            logic [7:0] b;
            b = 8'hB5;
            i2c_start();
            wr_byte(8'hC0, ack);
            wr_byte(8'h01, ack);
            for (int i = 7; i >= 0; i--) begin
                sda_m = b[i]; tick(Q / 2);
                glitch_scl = 1'b1; tick(1); glitch_scl = 1'b0; tick(Q / 2);
                scl_m = 1'b1; tick(Q / 2);
                glitch_sda = 1'b1; tick(1); glitch_sda = 1'b0; tick(Q / 2);
                scl_m = 1'b0; tick(Q);
            end
            bus_bit(1'b1, s);
            chk("R12 data ack despite spikes", {31'b0, ~s}, 32'd1);
            i2c_stop();
            m_ai = 1'b0; m_ptr = 3'd1; m_reg[1] = b;
            chk_ports("R12 spikes rejected");
        end

        // R9: reset in the middle of a write
        begin
            logic s;
            i2c_start();
            wr_byte(8'hC0, ack);
            wr_byte(8'h12, ack);
            bus_bit(1'b0, s);
            bus_bit(1'b0, s);
            rst_n = 1'b0; tick(5);
            chk("R9 SDA released during reset", {31'b0, sda_drv}, 32'd0);
            model_reset();
            chk_ports("R9 defaults during reset");
            rst_n = 1'b1; tick(10);
            i2c_stop();
            read_txn(8'h11, 5, "R9 R3 after reset");
        end

        // random mix
        for (int it = 0; it < 20; it++) begin
            int nb;
            logic [7:0] cmd;
            pins = 2'($urandom);
            nb = 1 + int'($urandom % 4);
            cmd = {3'b0, 1'($urandom), 1'b0, 3'($urandom)};
            for (int k = 0; k < nb; k++) wbuf[k] = 8'($urandom);
            write_txn(7'h60, cmd, nb, 1'b1, "R3 R5 R6 random write");
            chk_ports("R4 random write");
            cmd = {3'b0, 1'($urandom), 1'b0, 3'($urandom)};
            read_txn(cmd, 1 + int'($urandom % 3), "R8 random read");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule